// File: doc/BRIEF.md
# Variable-Block Reed-Solomon Systematic Encoder

This block encodes a stream of information symbols into Reed-Solomon codewords over GF(2^m). The code is systematic. Each information symbol reaches the output unchanged, and once the last one of a block has gone out, the block's check symbols follow back to back. The field polynomial is a parameter, given as its integer value at x=2. The generator polynomial is also fixed by parameters: a first root exponent and a root step. Its roots are alpha^(GEN_STEP*(GEN_START+i)) for i = 0 up to the check count minus 1, where alpha is the field element 2.

The codeword length and the check count can change from one block to the next. Both are taken from ports on the symbol that opens a block. The generator coefficients for every check count up to the maximum are computed while the design elaborates. At run time, the latched check count selects one set of them.

The host presents a symbol with `en_i` whenever `ready_o` is high. It marks the first symbol of a block with `blk_start_i`. Driving `bypass_i` sends a symbol straight to the output without encoding it. Output flags mark the following:
- valid symbols;
- check symbols;
- the first symbol of a block;
- the last check symbol of a block.

Top module: `rs_dyn_encoder`

## Requirements
- R1: Every information symbol of a block appears on `data_o` unchanged and in arrival order, with `valid_o`=1 and `status_o`=0.
- R2: Immediately after the last information symbol, exactly C check symbols follow on consecutive cycles, each with `status_o`=1. C is the block's check count. The n-symbol output c_0..c_(n-1), read as a polynomial with c_0 as the highest power, evaluates to zero at alpha^(GEN_STEP*(GEN_START+i)) for every i < C.
- R3: `blk_len_i` (codeword length n) and `chk_num_i` (C) are sampled only together with an accepted `blk_start_i`, and the block then carries n-C information symbols. Their values on any other accepted symbol have no effect. Legal values satisfy 1 <= C <= MAX_CHK and C < n <= MAX_LEN.
- R4: A symbol sampled at clock edge E appears on the outputs after edge E+LAT-1, where LAT = 2 + REG_IN. With the default REG_IN=1 this is 3 edges, counting E as the first.
- R5: `ready_o` is low for exactly C cycles, starting right after the edge that accepts the last information symbol. During those cycles, `en_i`, `blk_start_i` and `bypass_i` are ignored and produce no output.
- R6: An accepted `blk_start_i` in the middle of a block abandons that block. No check symbols are produced for the abandoned block, and the new block is encoded from that symbol onwards.
- R7: A symbol accepted with `bypass_i`=1 appears on the output with `status_o`=0 and `out_start_o`=0. It leaves the encoding state and the symbol count of any open block untouched.
- R8: `out_start_o` pulses with the first output symbol of each block. `out_end_o` pulses with its last check symbol. `valid_o` is high exactly on cycles that carry a symbol.
- R9: A non-bypass symbol accepted while no block is open and without `blk_start_i` is dropped and produces no output.
- R10: After reset, `ready_o`=1 and `valid_o`, `status_o`, `out_start_o` and `out_end_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Input symbol qualifier |
| bypass_i | input | 1 | Pass this symbol through unencoded |
| blk_start_i | input | 1 | First symbol of a new block |
| blk_len_i | input | LEN_W | Codeword length n, sampled at block start |
| chk_num_i | input | CHK_W | Check symbol count C, sampled at block start |
| data_i | input | SYM_W | Input symbol |
| ready_o | output | 1 | Input symbols accepted |
| data_o | output | SYM_W | Output symbol |
| valid_o | output | 1 | `data_o` carries a symbol |
| status_o | output | 1 | Output symbol is a check symbol |
| out_start_o | output | 1 | First output symbol of a block |
| out_end_o | output | 1 | Last check symbol of a block |

## Verification
The bench builds the encoder with its default parameters:
- GF(8) with field polynomial 11;
- up to 4 check symbols and codewords of up to 7 symbols;
- first root alpha^0 with a root step of 1;
- registered inputs.

This small field lets the bench sweep every legal pair of codeword length and check count, from (2,1) to (7,4), with several data patterns. It judges each codeword by evaluating it at every generator root in arithmetic of its own. Further directed runs cover input held during the check phase, restarts in mid-block, bypass symbols inside and outside a block, orphan symbols, and the exact latency.

// File: rtl/rs_enc_pkg.sv
`timescale 1ns/1ps
package rs_enc_pkg;

  // GF(2^m) product, shift-and-add, for elaboration-time use
  function automatic int gf_mul(int a, int b, int m, int poly);
    int r;
    int x;
    r = 0;
    x = a;
    for (int i = 0; i < m; i++) begin
      if (((b >> i) & 1) != 0) r = r ^ x;
      x = x << 1;
      if (((x >> m) & 1) != 0) x = x ^ poly;
    end
    return r;
  endfunction

  // alpha^e with alpha = 2
  function automatic int gf_pow(int e, int m, int poly);
    int r;
    int e2;
    r  = 1;
    e2 = e % ((1 << m) - 1);
    for (int i = 0; i < e2; i++) r = gf_mul(r, 2, m, poly);
    return r;
  endfunction

endpackage

// File: rtl/rs_in_stage.sv
`timescale 1ns/1ps
module rs_in_stage #(
  parameter int W   = 8,
  parameter bit REG = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] d_o
);
  if (REG) begin : g_reg
    logic [W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else         q <= d_i;
    end
    assign d_o = q;
  end else begin : g_thru
    assign d_o = d_i;
  end
endmodule

// File: rtl/rs_ctrl.sv
`timescale 1ns/1ps
module rs_ctrl #(
  parameter int SYM_W = 3,
  parameter int LEN_W = 3,
  parameter int CHK_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             byp_i,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [CHK_W-1:0] chk_i,
  input  logic [SYM_W-1:0] data_i,
  output logic             ready_o,
  output logic             tag_vld_o,
  output logic             tag_byp_o,
  output logic             tag_start_o,
  output logic             tag_last_o,
  output logic [CHK_W-1:0] tag_chk_o,
  output logic [SYM_W-1:0] tag_data_o
);
  logic             in_blk_q;
  logic [LEN_W-1:0] left_q;
  logic [CHK_W-1:0] chk_q, hold_q;

  logic             accept, take_start, take_cont, is_last;
  logic [LEN_W-1:0] info_cnt;
  logic [CHK_W-1:0] chk_eff;

  assign ready_o    = (hold_q == '0);
  assign accept     = en_i & ready_o;
  assign info_cnt   = len_i - LEN_W'(chk_i);
  assign take_start = accept & ~byp_i & start_i;
  assign take_cont  = accept & ~byp_i & ~start_i & in_blk_q;
  assign is_last    = take_start ? (info_cnt == LEN_W'(1))
                                 : (take_cont & (left_q == LEN_W'(1)));
  assign chk_eff    = take_start ? chk_i : chk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_blk_q <= 1'b0;
      left_q   <= '0;
      chk_q    <= '0;
      hold_q   <= '0;
    end else begin
      if (take_start) chk_q <= chk_i;
      if (take_start | take_cont) begin
        in_blk_q <= ~is_last;
        left_q   <= (take_start ? info_cnt : left_q) - LEN_W'(1);
      end
      // ready stays low while the check symbols drain
      if (is_last)              hold_q <= chk_eff;
      else if (hold_q != '0)    hold_q <= hold_q - CHK_W'(1);
    end
  end

  assign tag_vld_o   = accept & (byp_i | start_i | in_blk_q);
  assign tag_byp_o   = byp_i;
  assign tag_start_o = take_start;
  assign tag_last_o  = is_last;
  assign tag_chk_o   = chk_i;
  assign tag_data_o  = data_i;

  a_r5_ready_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_last |=> !ready_o);

endmodule

// File: rtl/rs_remainder.sv
`timescale 1ns/1ps
module rs_remainder #(
  parameter int SYM_W      = 3,
  parameter int CHK_W      = 3,
  parameter int MAX_CHK    = 4,
  parameter int FIELD_POLY = 11,
  parameter int GEN_START  = 0,
  parameter int GEN_STEP   = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tag_vld_i,
  input  logic             tag_byp_i,
  input  logic             tag_start_i,
  input  logic             tag_last_i,
  input  logic [CHK_W-1:0] tag_chk_i,
  input  logic [SYM_W-1:0] tag_data_i,
  output logic             e_vld_o,
  output logic             e_par_o,
  output logic             e_first_o,
  output logic             e_last_o,
  output logic [SYM_W-1:0] e_data_o
);
  localparam logic [SYM_W-1:0] POLY_LO = SYM_W'(FIELD_POLY);

  function automatic int gen_coef(int t, int j);
    int c [0:MAX_CHK];
    int root;
    for (int k = 0; k <= MAX_CHK; k++) c[k] = (k == 0) ? 1 : 0;
    for (int i = 0; i < MAX_CHK; i++) begin
      if (i < t) begin
        root = rs_enc_pkg::gf_pow(GEN_STEP * (GEN_START + i), SYM_W, FIELD_POLY);
        for (int k = MAX_CHK; k >= 1; k--)
          c[k] = c[k-1] ^ rs_enc_pkg::gf_mul(root, c[k], SYM_W, FIELD_POLY);
        c[0] = rs_enc_pkg::gf_mul(root, c[0], SYM_W, FIELD_POLY);
      end
    end
    return c[j];
  endfunction

  function automatic logic [SYM_W-1:0] fmul(logic [SYM_W-1:0] a, logic [SYM_W-1:0] b);
    logic [SYM_W-1:0] r, x;
    r = '0;
    x = a;
    for (int i = 0; i < SYM_W; i++) begin
      if (b[i]) r = r ^ x;
      x = {x[SYM_W-2:0], 1'b0} ^ (x[SYM_W-1] ? POLY_LO : '0);
    end
    return r;
  endfunction

  logic [SYM_W-1:0] gtab [1:MAX_CHK][0:MAX_CHK-1];
  for (genvar t = 1; t <= MAX_CHK; t++) begin : g_row
    for (genvar j = 0; j < MAX_CHK; j++) begin : g_col
      localparam logic [SYM_W-1:0] COEF = SYM_W'(gen_coef(t, j));
      assign gtab[t][j] = COEF;
    end
  end

  logic [MAX_CHK-1:0][SYM_W-1:0] rem_q, rem_nx;
  logic [CHK_W-1:0]              chk_q, par_q, t_eff;
  logic [SYM_W-1:0]              coef [0:MAX_CHK-1];
  logic [SYM_W-1:0]              fb, top_rx, top_tx, lower;

  function automatic logic [SYM_W-1:0] pick(logic [MAX_CHK-1:0][SYM_W-1:0] v,
                                            logic [CHK_W-1:0] n);
    logic [SYM_W-1:0] r;
    r = '0;
    for (int j = 0; j < MAX_CHK; j++)
      if (n == CHK_W'(j + 1)) r = v[j];
    return r;
  endfunction

  always_comb begin
    t_eff  = tag_start_i ? tag_chk_i : chk_q;
    top_rx = tag_start_i ? '0 : pick(rem_q, t_eff);
    top_tx = pick(rem_q, chk_q);
    fb     = tag_data_i ^ top_rx;
    for (int j = 0; j < MAX_CHK; j++) coef[j] = '0;
    for (int t = 1; t <= MAX_CHK; t++)
      if (t_eff == CHK_W'(t))
        for (int j = 0; j < MAX_CHK; j++) coef[j] = gtab[t][j];
    for (int j = 0; j < MAX_CHK; j++) begin
      lower     = (j == 0 || tag_start_i) ? '0 : rem_q[(j == 0) ? 0 : j-1];
      rem_nx[j] = (CHK_W'(j) < t_eff) ? (lower ^ fmul(coef[j], fb)) : '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q     <= '0;
      chk_q     <= '0;
      par_q     <= '0;
      e_vld_o   <= 1'b0;
      e_par_o   <= 1'b0;
      e_first_o <= 1'b0;
      e_last_o  <= 1'b0;
      e_data_o  <= '0;
    end else if (par_q != '0) begin
      e_vld_o   <= 1'b1;
      e_par_o   <= 1'b1;
      e_first_o <= 1'b0;
      e_last_o  <= (par_q == CHK_W'(1));
      e_data_o  <= top_tx;
      rem_q     <= {rem_q[MAX_CHK-2:0], SYM_W'(0)};
      par_q     <= par_q - CHK_W'(1);
    end else if (tag_vld_i) begin
      e_vld_o   <= 1'b1;
      e_par_o   <= 1'b0;
      e_first_o <= tag_start_i & ~tag_byp_i;
      e_last_o  <= 1'b0;
      e_data_o  <= tag_data_i;
      if (!tag_byp_i) begin
        rem_q <= rem_nx;
        if (tag_start_i) chk_q <= tag_chk_i;
        if (tag_last_i)  par_q <= t_eff;
      end
    end else begin
      e_vld_o   <= 1'b0;
      e_par_o   <= 1'b0;
      e_first_o <= 1'b0;
      e_last_o  <= 1'b0;
    end
  end

  a_r5_quiet_in_check_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (par_q != '0) |-> !tag_vld_i);
  a_r7_bypass_keeps_rem: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tag_vld_i && tag_byp_i && par_q == '0) |=> $stable(rem_q));
  a_r2_checks_contiguous: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (e_par_o && !e_last_o) |=> e_par_o);

endmodule

// File: rtl/rs_out_stage.sv
`timescale 1ns/1ps
module rs_out_stage #(
  parameter int SYM_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vld_i,
  input  logic             par_i,
  input  logic             first_i,
  input  logic             last_i,
  input  logic [SYM_W-1:0] data_i,
  output logic             valid_o,
  output logic             status_o,
  output logic             out_start_o,
  output logic             out_end_o,
  output logic [SYM_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o     <= 1'b0;
      status_o    <= 1'b0;
      out_start_o <= 1'b0;
      out_end_o   <= 1'b0;
      data_o      <= '0;
    end else begin
      valid_o     <= vld_i;
      status_o    <= par_i;
      out_start_o <= first_i;
      out_end_o   <= last_i;
      data_o      <= data_i;
    end
  end

  a_r8_end_on_check: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_end_o |-> (status_o && valid_o));
  a_r8_start_on_info: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_start_o |-> (!status_o && valid_o));

endmodule

// File: rtl/rs_dyn_encoder.sv
`timescale 1ns/1ps
module rs_dyn_encoder #(
  parameter int SYM_W      = 3,
  parameter int FIELD_POLY = 11,
  parameter int MAX_LEN    = 7,
  parameter int MAX_CHK    = 4,
  parameter int GEN_START  = 0,
  parameter int GEN_STEP   = 1,
  parameter bit REG_IN     = 1'b1,
  localparam int LEN_W     = $clog2(MAX_LEN + 1),
  localparam int CHK_W     = $clog2(MAX_CHK + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             bypass_i,
  input  logic             blk_start_i,
  input  logic [LEN_W-1:0] blk_len_i,
  input  logic [CHK_W-1:0] chk_num_i,
  input  logic [SYM_W-1:0] data_i,
  output logic             ready_o,
  output logic [SYM_W-1:0] data_o,
  output logic             valid_o,
  output logic             status_o,
  output logic             out_start_o,
  output logic             out_end_o
);
  localparam int TAG_W = 4 + CHK_W + SYM_W;

  logic             c_vld, c_byp, c_start, c_last;
  logic [CHK_W-1:0] c_chk;
  logic [SYM_W-1:0] c_data;
  logic [TAG_W-1:0] tag_raw, tag_reg;
  logic             r_vld, r_byp, r_start, r_last;
  logic [CHK_W-1:0] r_chk;
  logic [SYM_W-1:0] r_data;
  logic             e_vld, e_par, e_first, e_last;
  logic [SYM_W-1:0] e_data;

  rs_ctrl #(.SYM_W(SYM_W), .LEN_W(LEN_W), .CHK_W(CHK_W)) u_ctrl (
    .clk_i, .rst_ni,
    .en_i, .byp_i(bypass_i), .start_i(blk_start_i),
    .len_i(blk_len_i), .chk_i(chk_num_i), .data_i,
    .ready_o,
    .tag_vld_o(c_vld), .tag_byp_o(c_byp), .tag_start_o(c_start),
    .tag_last_o(c_last), .tag_chk_o(c_chk), .tag_data_o(c_data)
  );

  assign tag_raw = {c_vld, c_byp, c_start, c_last, c_chk, c_data};

  rs_in_stage #(.W(TAG_W), .REG(REG_IN)) u_in (
    .clk_i, .rst_ni, .d_i(tag_raw), .d_o(tag_reg)
  );

  assign {r_vld, r_byp, r_start, r_last, r_chk, r_data} = tag_reg;

  rs_remainder #(
    .SYM_W(SYM_W), .CHK_W(CHK_W), .MAX_CHK(MAX_CHK), .FIELD_POLY(FIELD_POLY),
    .GEN_START(GEN_START), .GEN_STEP(GEN_STEP)
  ) u_rem (
    .clk_i, .rst_ni,
    .tag_vld_i(r_vld), .tag_byp_i(r_byp), .tag_start_i(r_start),
    .tag_last_i(r_last), .tag_chk_i(r_chk), .tag_data_i(r_data),
    .e_vld_o(e_vld), .e_par_o(e_par), .e_first_o(e_first),
    .e_last_o(e_last), .e_data_o(e_data)
  );

  rs_out_stage #(.SYM_W(SYM_W)) u_out (
    .clk_i, .rst_ni,
    .vld_i(e_vld), .par_i(e_par), .first_i(e_first), .last_i(e_last), .data_i(e_data),
    .valid_o, .status_o, .out_start_o, .out_end_o, .data_o
  );

endmodule

// File: tb/rs_dyn_encoder_tb.sv
`timescale 1ns/1ps
module rs_dyn_encoder_tb;
  localparam int SW = 3, POLY = 11, MAXN = 7, MAXC = 4, GS = 0, GSTEP = 1, LAT = 3;
  localparam int LW = 3, CW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 1'b0, byp = 1'b0, st = 1'b0;
  logic [LW-1:0] len = '0;
  logic [CW-1:0] chk = '0;
  logic [SW-1:0] din = '0;
  logic ready_o, valid_o, status_o, out_start_o, out_end_o;
  logic [SW-1:0] data_o;

  always #10 clk = ~clk;

  rs_dyn_encoder u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .bypass_i(byp), .blk_start_i(st),
    .blk_len_i(len), .chk_num_i(chk), .data_i(din),
    .ready_o, .data_o, .valid_o, .status_o, .out_start_o, .out_end_o
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int m_d [0:255], m_s [0:255], m_bs [0:255], m_be [0:255], m_c [0:255];
  int m_n = 0;
  always @(negedge clk) begin
    if (rst_n && valid_o && m_n < 256) begin
      m_d[m_n]  = int'(data_o);
      m_s[m_n]  = int'(status_o);
      m_bs[m_n] = int'(out_start_o);
      m_be[m_n] = int'(out_end_o);
      m_c[m_n]  = cyc;
      m_n++;
    end
  end

  int n_chk = 0, n_fail = 0;
  int sent [0:15];

  task automatic check(string rq, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic int gmul(int a, int b);
    int r = 0;
    for (int i = 0; i < SW; i++) begin
      if (((b >> i) & 1) != 0) r ^= a;
      a = a << 1;
      if ((a & (1 << SW)) != 0) a ^= POLY;
    end
    return r;
  endfunction

  function automatic int gpow(int e);
    int r = 1;
    for (int i = 0; i < e % ((1 << SW) - 1); i++) r = gmul(r, 2);
    return r;
  endfunction

  task automatic send(int d, bit s, bit b, int n, int c);
    en = 1'b1; st = s; byp = b; din = SW'(d); len = LW'(n); chk = CW'(c);
    @(negedge clk);
    en = 1'b0; st = 1'b0; byp = 1'b0;
  endtask

  task automatic idle(int k);
    en = 1'b0;
    repeat (k) @(negedge clk);
  endtask

  task automatic wait_ready();
    while (!ready_o) @(negedge clk);
  endtask

  // codeword laid out from index base, skipping one output index
  task automatic check_block(string rq, int base, int skip, int k, int c);
    int idx [0:15];
    int p = 0;
    int acc, x;
    for (int q = base; p < k + c; q++) begin
      if (q != skip) begin
        idx[p] = q;
        p++;
      end
    end
    for (int j = 0; j < k; j++) begin
      check({rq, " R1 info symbol"}, m_d[idx[j]], sent[j]);
      check({rq, " R1 info status"}, m_s[idx[j]], 0);
    end
    check({rq, " R8 start flag"}, m_bs[idx[0]], 1);
    for (int j = 0; j < c; j++) begin
      check({rq, " R2 check status"}, m_s[idx[k+j]], 1);
      check({rq, " R2 check contiguous"}, m_c[idx[k+j]], m_c[idx[k-1]] + j + 1);
    end
    check({rq, " R8 end flag"}, m_be[idx[k+c-1]], 1);
    for (int i = 0; i < c; i++) begin
      x   = gpow(GSTEP * (GS + i));
      acc = 0;
      for (int j = 0; j < k + c; j++) acc = gmul(acc, x) ^ m_d[idx[j]];
      check({rq, " R2 root syndrome"}, acc, 0);
    end
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL R4 watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int t0, k, cnt, nstart, npar, nend;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 ready", int'(ready_o), 1);
    check("R10 valid", int'(valid_o), 0);
    check("R10 status", int'(status_o), 0);
    check("R10 out_start", int'(out_start_o), 0);
    check("R10 out_end", int'(out_end_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // sweep all legal (n, C); junk length/count on non-start symbols (R3)
    for (int n = 2; n <= MAXN; n++) begin
      for (int c = 1; c <= MAXC; c++) begin
        if (c < n) begin
          for (int p = 0; p < 4; p++) begin
            k = n - c;
            for (int j = 0; j < k; j++)
              sent[j] = (p == 0) ? (j * 3 + n + c) % 8 : (p == 1) ? 7 :
                        (p == 2) ? ((j == 0) ? 1 : 0) : (j * 5 + 2) % 8;
            wait_ready();
            m_n = 0;
            t0  = cyc;
            for (int j = 0; j < k; j++)
              if (j == 0) send(sent[j], 1'b1, 1'b0, n, c);
              else        send(sent[j], 1'b0, 1'b0, (j + 5) % 8, j % 5);
            idle(LAT + c + 3);
            check("R2 R3 output count", m_n, n);
            check("R4 latency", m_c[0], t0 + LAT);
            check_block("sweep R3", 0, -1, k, c);
          end
        end
      end
    end

    // R5: input held during check phase is ignored
    wait_ready();
    m_n = 0;
    for (int j = 0; j < 3; j++) sent[j] = j + 4;
    send(sent[0], 1'b1, 1'b0, 6, 3);
    send(sent[1], 1'b0, 1'b0, 6, 3);
    send(sent[2], 1'b0, 1'b0, 6, 3);
    check("R5 ready low after last", int'(ready_o), 0);
    cnt = 0;
    while (!ready_o) begin
      cnt++;
      en = 1'b1; st = 1'b1; byp = cnt[0]; din = 3'd5; len = 3'd7; chk = 3'd2;
      @(negedge clk);
    end
    en = 1'b0; st = 1'b0; byp = 1'b0;
    check("R5 ready low cycles", cnt, 3);
    idle(LAT + 6);
    check("R5 ignored output count", m_n, 6);
    check_block("R5", 0, -1, 3, 3);

    // R6: restart in mid-block
    wait_ready();
    m_n = 0;
    send(6, 1'b1, 1'b0, 7, 4);
    send(2, 1'b0, 1'b0, 7, 4);
    sent[0] = 3; sent[1] = 0; sent[2] = 5;
    send(sent[0], 1'b1, 1'b0, 5, 2);
    send(sent[1], 1'b0, 1'b0, 5, 2);
    send(sent[2], 1'b0, 1'b0, 5, 2);
    idle(LAT + 6);
    check("R6 output count", m_n, 7);
    check("R6 abandoned sym0", m_d[0], 6);
    check("R6 abandoned sym1", m_d[1], 2);
    nstart = 0; npar = 0; nend = 0;
    for (int j = 0; j < m_n; j++) begin
      nstart += m_bs[j]; npar += m_s[j]; nend += m_be[j];
    end
    check("R6 start flags", nstart, 2);
    check("R6 check symbols only for new block", npar, 2);
    check("R6 end flags", nend, 1);
    check_block("R6", 2, -1, 3, 2);

    // R7: bypass inside a block
    wait_ready();
    m_n = 0;
    sent[0] = 1; sent[1] = 7; sent[2] = 4;
    send(sent[0], 1'b1, 1'b0, 5, 2);
    send(6, 1'b1, 1'b1, 3, 1);
    send(sent[1], 1'b0, 1'b0, 5, 2);
    send(sent[2], 1'b0, 1'b0, 5, 2);
    idle(LAT + 5);
    check("R7 output count", m_n, 6);
    check("R7 bypass data", m_d[1], 6);
    check("R7 bypass status", m_s[1], 0);
    check("R7 bypass no start flag", m_bs[1], 0);
    check_block("R7", 0, 1, 3, 2);

    // R7: bypass outside a block
    m_n = 0;
    t0 = cyc;
    send(2, 1'b0, 1'b1, 0, 0);
    idle(LAT + 2);
    check("R7 idle bypass count", m_n, 1);
    check("R7 idle bypass data", m_d[0], 2);
    check("R7 idle bypass status", m_s[0], 0);
    check("R4 R7 bypass latency", m_c[0], t0 + LAT);

    // R9: orphan symbol without block start
    m_n = 0;
    send(5, 1'b0, 1'b0, 7, 4);
    send(3, 1'b0, 1'b0, 7, 4);
    idle(LAT + 4);
    check("R9 orphan dropped", m_n, 0);
    check("R9 ready kept", int'(ready_o), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule